// File: doc/BRIEF.md
# Self-Timed Word-Array Program Sequencer

This block carries out the internally timed erase and program cycles of a word-organized non-volatile array. The array is modelled as a synchronous register file of 16-bit words, clocked by the fast system clock. Millisecond program times are stood in for by cycle-count budgets set through parameters. A front end, outside this block, decodes serial commands and hands them to the sequencer one per cycle as a request: unlock, lock, erase one word, write one word, erase every word, or write every word. The request carries an address and a 16-bit data value. The sequencer raises `busy` for the whole budget of the operation and drives the array write strobe, address and data. It lowers `busy` once the operation is over.

Writes are guarded by a program-enable latch. The latch comes out of reset locked, and it changes only when an unlock or lock command is accepted. A word write always erases its word before programming it. A write-all always sweeps an erase over the whole array before its programming sweep. Once an operation has started, nothing at the request port can shorten it or redirect it. A separate read port returns any word one cycle after it is addressed, whatever the state of the latch or of `busy`.

Top module: `nvm_prog_seq`

## Requirements
- R1: After synchronous reset, `busy` and `arr_we` are 0, the program-enable latch is locked, and every word reads 16'hFFFF.
- R2: While the latch is locked, a program request (code 2, 3, 4 or 5) is ignored. `busy` stays 0 and no word changes.
- R3: Code 0 sets the latch and code 1 clears it. The latch keeps its value across any number of program operations.
- R4: Code 2 (erase word) keeps `busy` high for exactly T_WORD cycles and issues one array write, which sets the addressed word to 16'hFFFF.
- R5: Code 3 (write word) keeps `busy` high for exactly T_WORD cycles. The word reads 16'hFFFF once the first T_WORD/2 cycles are over, and it holds the request data when `busy` falls. Two array writes are issued.
- R6: Code 4 (erase all) keeps `busy` high for exactly T_ERALL cycles. Its last DEPTH busy cycles write 16'hFFFF to addresses 0 up to DEPTH-1 in ascending order.
- R7: Code 5 (write all) keeps `busy` high for exactly T_WRALL cycles. The first T_WRALL/2 cycles end with an erase sweep of the whole array, and the rest end with a sweep that programs every word with the request data. 2*DEPTH array writes are issued in total.
- R8: Every request that arrives while `busy` is high is dropped, unlock and lock included. The running operation keeps its full budget and its target.
- R9: `arr_we` is high only while `busy` is high. The last array write of an operation happens in its final busy cycle, and `busy` is 0 in the cycle after it.
- R10: `rd_data` shows the word at `rd_addr` as it stood before the previous clock edge, whatever the latch and `busy` are doing.
- R11: Codes 6 and 7 have no effect. They change neither the latch nor `busy` nor any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 3 | Command code (0 unlock, 1 lock, 2 erase word, 3 write word, 4 erase all, 5 write all) |
| req_addr | input | ADDR_W | Target word address for word commands |
| req_data | input | 16 | Data for write word and write all |
| rd_addr | input | ADDR_W | Read port address |
| rd_data | output | 16 | Read port data, one cycle latency |
| busy | output | 1 | Timed operation in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | 16 | Array write data |

## Verification
The hardest conditions to reach from the ports are two short windows. The first is the single cycle in which a word write has erased its target but not yet programmed it. The second is a request that lands in the middle of a long write-all. The bench parks the read address on the target and samples the read port in the cycle on each side of the erase boundary, working the boundary out from T_WORD/2. It also injects a word write, an erase and a lock at fixed offsets into a write-all. It then confirms that the total busy length, the array contents and the state of the latch are those of the write-all alone. Random command streams drawn from a fixed seed then mix locked and unlocked program requests with reserved codes, and every result is compared with a bench model of the array.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;

    localparam int WORD_W = 16;
    localparam logic [WORD_W-1:0] ERASED_WORD = '1;

    typedef enum logic [2:0] {
        CMD_UNLOCK   = 3'd0,
        CMD_LOCK     = 3'd1,
        CMD_CLR_WORD = 3'd2,
        CMD_PUT_WORD = 3'd3,
        CMD_CLR_ALL  = 3'd4,
        CMD_PUT_ALL  = 3'd5,
        CMD_RSV6     = 3'd6,
        CMD_RSV7     = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ERASE,
        PH_PROG
    } phase_e;

    typedef struct packed {
        cmd_e              cmd;
        logic              bulk;
        logic              two_phase;
        logic [WORD_W-1:0] data;
    } job_t;

    function automatic logic is_program(cmd_e c);
        return (c == CMD_CLR_WORD) || (c == CMD_PUT_WORD) ||
               (c == CMD_CLR_ALL)  || (c == CMD_PUT_ALL);
    endfunction

    function automatic logic is_bulk(cmd_e c);
        return (c == CMD_CLR_ALL) || (c == CMD_PUT_ALL);
    endfunction

    function automatic logic needs_prog(cmd_e c);
        return (c == CMD_PUT_WORD) || (c == CMD_PUT_ALL);
    endfunction

endpackage

// File: rtl/nvm_wen_latch.sv
module nvm_wen_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_en,
    input  logic clr_en,
    output logic en_q
);
    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else if (clr_en)
            en_q <= 1'b0;
        else if (set_en)
            en_q <= 1'b1;
    end

    // R1: locked in the first cycle after reset
    a_r1_locked_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> !en_q);
endmodule

// File: rtl/nvm_phase_timer.sv
module nvm_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             zero
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R8: a running budget is never cut short by a new load
    a_r8_no_truncation: assert property (@(posedge clk) disable iff (rst)
        load |-> (cnt_q == '0));
endmodule

// File: rtl/nvm_word_array.sv
module nvm_word_array
    import nvm_prog_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= ERASED_WORD;
            rdata <= ERASED_WORD;
        end else begin
            if (we)
                mem_q[waddr] <= wdata;
            rdata <= mem_q[raddr];
        end
    end
endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
    import nvm_prog_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int T_WORD  = 50,
    parameter int T_ERALL = 150,
    parameter int T_WRALL = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [WORD_W-1:0] arr_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(T_WRALL + 1);
    localparam logic [CNT_W-1:0] SWEEP_LIM   = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LD_WORD     = CNT_W'(T_WORD - 1);
    localparam logic [CNT_W-1:0] LD_WORD_ER  = CNT_W'(T_WORD / 2 - 1);
    localparam logic [CNT_W-1:0] LD_WORD_PG  = CNT_W'(T_WORD - T_WORD / 2 - 1);
    localparam logic [CNT_W-1:0] LD_ALL_ER   = CNT_W'(T_ERALL - 1);
    localparam logic [CNT_W-1:0] LD_WALL_ER  = CNT_W'(T_WRALL / 2 - 1);
    localparam logic [CNT_W-1:0] LD_WALL_PG  = CNT_W'(T_WRALL - T_WRALL / 2 - 1);
    localparam logic [ADDR_W-1:0] TOP_ADDR   = ADDR_W'(DEPTH - 1);

    cmd_e              cmd_in;
    phase_e            phase_q, phase_d;
    job_t              job_q;
    logic [ADDR_W-1:0] addr_q;
    logic              idle, take, launch, en_q;
    logic              tmr_load, tmr_zero;
    logic [CNT_W-1:0]  tmr_val, tmr_cnt;
    logic [CNT_W-1:0]  first_ld, second_ld;
    logic              in_sweep;
    logic [ADDR_W-1:0] sweep_addr;

    assign cmd_in = cmd_e'(req_cmd);
    assign idle   = (phase_q == PH_IDLE);
    assign busy   = !idle;
    assign take   = req_valid && idle;
    assign launch = take && en_q && is_program(cmd_in);

    nvm_wen_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .set_en (take && (cmd_in == CMD_UNLOCK)),
        .clr_en (take && (cmd_in == CMD_LOCK)),
        .en_q   (en_q)
    );

    nvm_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt_q    (tmr_cnt),
        .zero     (tmr_zero)
    );

    // Length of the opening (erase) phase for an incoming command
    always_comb begin
        case (cmd_in)
            CMD_CLR_WORD: first_ld = LD_WORD;
            CMD_PUT_WORD: first_ld = LD_WORD_ER;
            CMD_CLR_ALL:  first_ld = LD_ALL_ER;
            CMD_PUT_ALL:  first_ld = LD_WALL_ER;
            default:      first_ld = '0;
        endcase
    end

    // Length of the programming phase for the job in flight
    assign second_ld = job_q.bulk ? LD_WALL_PG : LD_WORD_PG;

    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (phase_q)
            PH_IDLE: begin
                if (launch) begin
                    phase_d  = PH_ERASE;
                    tmr_load = 1'b1;
                    tmr_val  = first_ld;
                end
            end
            PH_ERASE: begin
                if (tmr_zero) begin
                    if (job_q.two_phase) begin
                        phase_d  = PH_PROG;
                        tmr_load = 1'b1;
                        tmr_val  = second_ld;
                    end else begin
                        phase_d = PH_IDLE;
                    end
                end
            end
            PH_PROG: begin
                if (tmr_zero)
                    phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            job_q   <= '0;
            addr_q  <= '0;
        end else begin
            phase_q <= phase_d;
            if (launch) begin
                job_q.cmd       <= cmd_in;
                job_q.bulk      <= is_bulk(cmd_in);
                job_q.two_phase <= needs_prog(cmd_in);
                job_q.data      <= req_data;
                addr_q          <= req_addr;
            end
        end
    end

    // Write port: a single write at the end of a word phase, or an
    // ascending sweep over the last DEPTH cycles of a bulk phase.
    assign in_sweep   = (tmr_cnt < SWEEP_LIM);
    assign sweep_addr = TOP_ADDR - tmr_cnt[ADDR_W-1:0];
    assign arr_we     = busy && (job_q.bulk ? in_sweep : tmr_zero);
    assign arr_addr   = job_q.bulk ? sweep_addr : addr_q;
    assign arr_data   = (phase_q == PH_PROG) ? job_q.data : ERASED_WORD;

    nvm_word_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (arr_we),
        .waddr (arr_addr),
        .wdata (arr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // R2: a locked latch keeps program requests from starting
    a_r2_locked_no_start: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !en_q && is_program(cmd_in)) |=> !busy);

    // R3: the latch only drops after an accepted lock command
    a_r3_lock_only_by_cmd: assert property (@(posedge clk) disable iff (rst)
        $fell(en_q) |-> $past(req_valid && !busy && (req_cmd == 3'd1)));

    // R8: the latch cannot change while an operation runs
    a_r8_latch_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(en_q));

    // R9: writes only while busy, and busy falls right after the last write
    a_r9_write_inside_busy: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);
    a_r9_fall_after_write: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(arr_we));
endmodule

// File: tb/sim_nvm_prog_seq.sv
module sim_nvm_prog_seq;
    import nvm_prog_pkg::*;

    localparam int AW  = 6;
    localparam int DEP = 1 << AW;
    localparam int TW  = 50;
    localparam int TE  = 150;
    localparam int TA  = 200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [2:0]    req_cmd = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic          busy, arr_we;
    logic [AW-1:0] arr_addr;
    logic [15:0]   arr_data;

    nvm_prog_seq #(.ADDR_W(AW), .T_WORD(TW), .T_ERALL(TE), .T_WRALL(TA)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_data(req_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_data(arr_data)
    );

    always #2 clk = ~clk;

    int          checks = 0;
    int          errors = 0;
    logic [15:0] model [DEP];
    bit          model_en = 1'b0;

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int budget(int c);
        case (c)
            2, 3:    return TW;
            4:       return TE;
            5:       return TA;
            default: return 0;
        endcase
    endfunction

    function automatic int write_count(int c);
        case (c)
            2:       return 1;
            3:       return 2;
            4:       return DEP;
            5:       return 2 * DEP;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int c, bit en);
        if (c >= 2 && c <= 5 && !en) return "R2";
        case (c)
            0, 1:    return "R3";
            2:       return "R4";
            3:       return "R5";
            4:       return "R6";
            5:       return "R7";
            default: return "R11";
        endcase
    endfunction

    function automatic void model_apply(int c, int a, logic [15:0] d);
        case (c)
            0: model_en = 1'b1;
            1: model_en = 1'b0;
            2: if (model_en) model[a] = 16'hFFFF;
            3: if (model_en) model[a] = d;
            4: if (model_en) for (int i = 0; i < DEP; i++) model[i] = 16'hFFFF;
            5: if (model_en) for (int i = 0; i < DEP; i++) model[i] = d;
            default: ;
        endcase
    endfunction

    task automatic pulse(int c, int a, logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_cmd   = 3'(c);
        req_addr  = AW'(a);
        req_data  = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n, output int nwe, output bit last_we,
                             output int last_addr);
        n = 0; nwe = 0; last_we = 1'b0; last_addr = -1;
        while (busy && n < 1000) begin
            last_we = arr_we;
            if (arr_we) begin
                nwe++;
                last_addr = int'(arr_addr);
            end
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_op(int c, int a, logic [15:0] d);
        bit    prog;
        string tg;
        int    n, nwe, la;
        bit    lw;
        prog = (c >= 2 && c <= 5) && model_en;
        tg   = tag_of(c, model_en);
        pulse(c, a, d);
        wait_idle(n, nwe, lw, la);
        chk(n == (prog ? budget(c) : 0), tg, n, prog ? budget(c) : 0);
        chk(nwe == (prog ? write_count(c) : 0), tg, nwe, prog ? write_count(c) : 0);
        if (prog) begin
            chk(lw, "R9", lw, 1);
            chk(la == ((c >= 4) ? DEP - 1 : a), (c >= 4) ? "R6" : tg, la,
                (c >= 4) ? DEP - 1 : a);
        end
        chk(arr_we == 1'b0, "R9", arr_we, 0);
        model_apply(c, a, d);
    endtask

    task automatic rd_chk(int a, string tag);
        @(negedge clk);
        rd_addr = AW'(a);
        @(negedge clk);
        chk(rd_data == model[a], tag, rd_data, model[a]);
    endtask

    task automatic sweep_chk(string tag);
        for (int i = 0; i < DEP; i++) rd_chk(i, tag);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        int n, nwe, la, m;
        bit lw;
        void'($urandom(32'd9173));
        for (int i = 0; i < DEP; i++) model[i] = 16'hFFFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk(busy == 1'b0, "R1", busy, 0);
        chk(arr_we == 1'b0, "R1", arr_we, 0);
        rd_chk(0, "R1");
        rd_chk(DEP - 1, "R1");
        // R1/R2: latch is locked after reset
        run_op(3, 4, 16'h0000);
        rd_chk(4, "R2");

        // R3: unlock, then word write R5
        run_op(0, 0, 16'h0);
        run_op(3, 3, 16'h1234);
        rd_chk(3, "R5");

        // R2: lock and try every program command; R10 read while locked
        run_op(1, 0, 16'h0);
        run_op(2, 3, 16'h0);
        run_op(4, 0, 16'h0);
        run_op(5, 0, 16'h5555);
        rd_chk(3, "R10");

        // R11: reserved codes change nothing, latch stays unlocked
        run_op(0, 0, 16'h0);
        run_op(6, 3, 16'hDEAD);
        run_op(7, 3, 16'hBEEF);
        rd_chk(3, "R11");
        run_op(2, 3, 16'h0);
        rd_chk(3, "R4");

        // R5: erase boundary inside a word write, R10 read during busy
        run_op(3, 10, 16'hA5A5);
        @(negedge clk);
        rd_addr = AW'(10);
        pulse(3, 10, 16'h0F0F);
        repeat (TW / 2) @(negedge clk);
        chk(rd_data == 16'hA5A5, "R5", rd_data, 16'hA5A5);
        @(negedge clk);
        chk(rd_data == 16'hFFFF, "R5", rd_data, 16'hFFFF);
        chk(busy == 1'b1, "R10", busy, 1);
        wait_idle(n, nwe, lw, la);
        chk(n == TW - TW / 2 - 1, "R5", n, TW - TW / 2 - 1);
        model_apply(3, 10, 16'h0F0F);
        rd_chk(10, "R5");

        // R6 and R7 bulk operations
        run_op(4, 0, 16'h0);
        sweep_chk("R6");
        run_op(5, 0, 16'hC3C3);
        sweep_chk("R7");

        // R8: requests injected while write-all runs are dropped
        pulse(5, 0, 16'h7E81);
        m = 0;
        while (busy && m < 1000) begin
            if (m == 10) begin
                req_valid = 1'b1; req_cmd = 3'd3; req_addr = AW'(5); req_data = 16'h0001;
            end else if (m == 11) begin
                req_cmd = 3'd1;
            end else if (m == 12) begin
                req_cmd = 3'd2;
            end else if (m == 13) begin
                req_valid = 1'b0;
            end
            m++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(m == TA, "R8", m, TA);
        model_apply(5, 0, 16'h7E81);
        sweep_chk("R8");
        run_op(2, 5, 16'h0);   // still unlocked: full word budget expected
        rd_chk(5, "R8");

        // Random mix from a fixed seed
        for (int k = 0; k < 40; k++) begin
            int c, a;
            logic [15:0] d;
            c = int'($urandom % 8);
            a = int'($urandom % DEP);
            d = 16'($urandom);
            run_op(c, a, d);
            for (int j = 0; j < 3; j++) rd_chk(int'($urandom % DEP), "R10");
        end
        sweep_chk("R10");

        finish_run();
    end
endmodule